// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Typed Invalidation

This block is a small, fully associative translation cache. Each entry holds one virtual-to-physical page translation, a 12-bit address-space tag and a global flag. Translations from several address spaces can stay resident at once. A context switch only changes the `cur_ctx` input and does not flush anything. A lookup can only use entries tagged with the current context, or entries marked global.

New translations arrive on a fill port and take the context that is current in the fill cycle. A command port carries invalidation requests. Each request has a type code and a descriptor made of a context tag and a virtual page. The four legal types cover these cases:
- a single page in a single context;
- a whole context;
- everything except global entries;
- everything including global entries.

An invalidation completes in the cycle it is presented. A lookup in that same cycle already sees its effect. Any other type code is dropped and reported on a one-cycle error flag.

Top module: `ctx_tlb`

## Requirements
- R1: After a synchronous active-low reset, every entry is invalid, every lookup misses, and both `lk_hit` and `inv_err` are 0.
- R2: A fill writes the translation with the tag `cur_ctx` of the fill cycle. A lookup presented with `lk_valid` in cycle N yields `lk_hit`/`lk_ppn` in cycle N+1. A non-global entry hits only when its tag equals `cur_ctx` and its page equals `lk_vpn`. On a miss `lk_ppn` is 0. After a cycle without `lk_valid`, `lk_hit` is 0. When several entries match, the lowest-numbered entry supplies the result.
- R3: An entry written with `fill_global`=1 hits for its page under any value of `cur_ctx`.
- R4: Entries tagged with other contexts stay resident and hit again once `cur_ctx` returns to their tag.
- R5: Type code 0 removes the non-global entries whose tag equals `inv_ctx` and whose page equals `inv_vpn`. Global entries are kept.
- R6: Type code 1 removes every non-global entry whose tag equals `inv_ctx`. Entries of other contexts and global entries are kept.
- R7: Type code 2 removes every entry, global ones included.
- R8: Type code 3 removes every non-global entry in every context and keeps the global entries.
- R9: A lookup sees the state after the invalidation of its own cycle, and before the fill of its own cycle. If a fill and an invalidation share a cycle, the invalidation is applied first and the fill is then written.
- R10: A fill whose page would hit under the current context overwrites the lowest-numbered such entry in place. No duplicate is created.
- R11: The cache has 16 entries. A fill that matches no entry is written at a round-robin pointer. The pointer advances by one, wrapping, only on such new allocations. Reset returns it to entry 0, and invalidations do not move it.
- R12: Type codes 4 to 7 change no entry. They set `inv_err` to 1 for exactly the cycle after the command, and `inv_err` is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_ctx | input | 12 | Context tag of the current address space |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page to look up |
| lk_hit | output | 1 | Registered lookup hit |
| lk_ppn | output | 20 | Registered physical page (0 on miss) |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page of the fill |
| fill_ppn | input | 20 | Physical page of the fill |
| fill_global | input | 1 | Fill is global |
| inv_valid | input | 1 | Invalidation command strobe |
| inv_type | input | 3 | Invalidation type code (0..3 legal) |
| inv_ctx | input | 12 | Descriptor context tag |
| inv_vpn | input | 20 | Descriptor virtual page |
| inv_err | output | 1 | One-cycle flag for an illegal type code |

## Verification
`lk_hit`, `lk_ppn` and `inv_err` are all due one clock after the inputs that cause them. Entry state changes at the same edge, so a lookup in the following cycle reflects a fill or invalidation issued in the current cycle. The bench drives every input on the falling edge and computes the expected results from its own model in that cycle. It then waits for the next rising edge and compares the outputs on the falling edge after it, which is half a period away from any update. Lookups issued in the same cycle as an invalidation or a fill are checked against the post-invalidation, pre-fill state of the model.

// File: rtl/ctx_tlb_pkg.sv
// Package: shared type codes for the context-tagged translation cache.
// Assumes a 3-bit command code field; codes above 3 are illegal.
package ctx_tlb_pkg;

    typedef enum logic [2:0] {
        INV_PAGE    = 3'd0,  // one page of one context, globals kept
        INV_CONTEXT = 3'd1,  // whole context, globals kept
        INV_ALL_G   = 3'd2,  // everything, globals too
        INV_ALL     = 3'd3   // everything except globals
    } inv_kind_e;

    // Tell whether a command code is one of the four defined kinds.
    function automatic logic inv_code_legal(input logic [2:0] code);
        return code <= 3'd3;
    endfunction

endpackage

// File: rtl/ctx_tlb_entry.sv
// Module: one translation slot. Holds valid, global flag, context tag,
// virtual and physical page. Computes its own invalidation kill and its
// lookup/fill match against the post-invalidation state.
// Assumes inv_go is only raised for legal command codes.
module ctx_tlb_entry
    import ctx_tlb_pkg::*;
#(
    parameter int CTX_W = 12,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTX_W-1:0] cur_ctx,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_glb,
    input  logic             wr_en,
    input  logic             inv_go,
    input  logic [2:0]       inv_kind,
    input  logic [CTX_W-1:0] inv_ctx,
    input  logic [VPN_W-1:0] inv_vpn,
    output logic             lk_match,
    output logic             fill_match,
    output logic [PPN_W-1:0] ppn_o
);

    logic             valid_q;
    logic             glb_q;
    logic [CTX_W-1:0] ctx_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             kill;
    logic             valid_post;
    logic             ctx_ok;

    // Decide whether this cycle's invalidation removes the slot.
    always_comb begin
        kill = 1'b0;
        if (inv_go && valid_q) begin
            case (inv_kind)
                INV_PAGE:    kill = !glb_q && (ctx_q == inv_ctx) && (vpn_q == inv_vpn);
                INV_CONTEXT: kill = !glb_q && (ctx_q == inv_ctx);
                INV_ALL_G:   kill = 1'b1;
                INV_ALL:     kill = !glb_q;
                default:     kill = 1'b0;
            endcase
        end
    end

    // Match against the state as it stands after the invalidation.
    always_comb begin
        valid_post = valid_q && !kill;
        ctx_ok     = glb_q || (ctx_q == cur_ctx);
        lk_match   = valid_post && ctx_ok && (vpn_q == lk_vpn);
        fill_match = valid_post && ctx_ok && (vpn_q == fill_vpn);
        ppn_o      = ppn_q;
    end

    // Slot storage: a fill writes everything, otherwise apply the kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            glb_q   <= 1'b0;
            ctx_q   <= '0;
            vpn_q   <= '0;
            ppn_q   <= '0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
            glb_q   <= fill_glb;
            ctx_q   <= cur_ctx;
            vpn_q   <= fill_vpn;
            ppn_q   <= fill_ppn;
        end else begin
            valid_q <= valid_post;
        end
    end

    // R2: a write always leaves the slot valid with the current tag.
    p_fill_tags_current_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q && ctx_q == $past(cur_ctx)));

    // R7: a full flush empties the slot unless it is refilled.
    p_flush_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_go && inv_kind == INV_ALL_G && !wr_en) |=> !valid_q);

    // R8: a non-global flush keeps a valid global slot.
    p_global_survives_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_go && inv_kind == INV_ALL && valid_q && glb_q && !wr_en) |=> valid_q);

    // R6: a context flush leaves slots of other contexts untouched.
    p_other_ctx_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_go && inv_kind == INV_CONTEXT && valid_q && ctx_q != inv_ctx && !wr_en)
        |=> valid_q);

    // R12: without a legal command or a write the slot keeps its state.
    p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_go && !wr_en) |=> $stable(valid_q));

endmodule

// File: rtl/ctx_tlb_pick.sv
// Module: lowest-index priority picker over a request vector.
// Gives a one-hot grant, its index and an any-request flag.
// Assumes N >= 2.
module ctx_tlb_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Scan from the top so the lowest set bit is the last one kept.
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx = IDX_W'(i);
            end
        end
        any = |req;
    end

    // The grant is at most one-hot and present exactly when a request is.
    always_comb begin
        a_grant_onehot_r10: assert ($onehot0(grant) && ((grant != '0) == any));
    end

endmodule

// File: rtl/ctx_tlb_rr.sv
// Module: round-robin allocation pointer for new translations.
// Advances by one, wrapping at N, only when asked to allocate.
module ctx_tlb_rr #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    // Pointer update with wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (alloc) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // R11: each allocation steps the pointer by exactly one slot.
    p_rr_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

    // R11: with no allocation the pointer holds.
    p_rr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc |=> $stable(ptr));

endmodule

// File: rtl/ctx_tlb.sv
// Module: fully associative context-tagged translation cache (top).
// Lookup compares combinationally and registers the result one cycle
// later. Invalidations act in a single cycle and are visible to a lookup
// in the same cycle; a same-cycle fill is written after the invalidation.
// Assumes at most one fill, one lookup and one command per cycle.
module ctx_tlb
    import ctx_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int CTX_W   = 12,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTX_W-1:0] cur_ctx,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_global,
    input  logic             inv_valid,
    input  logic [2:0]       inv_type,
    input  logic [CTX_W-1:0] inv_ctx,
    input  logic [VPN_W-1:0] inv_vpn,
    output logic             inv_err
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic                 inv_legal;
    logic                 inv_go;
    logic [ENTRIES-1:0]   lk_match;
    logic [ENTRIES-1:0]   fill_match;
    logic [ENTRIES-1:0]   wr_en;
    logic [ENTRIES-1:0]   lk_grant;
    logic [ENTRIES-1:0]   fill_grant;
    logic [IDX_W-1:0]     lk_idx;
    logic [IDX_W-1:0]     fill_idx;
    logic                 lk_any;
    logic                 fill_any;
    logic [IDX_W-1:0]     rr_ptr;
    logic                 alloc;
    logic [PPN_W-1:0]     ppn_arr [ENTRIES];
    logic [PPN_W-1:0]     ppn_sel;
    logic [ENTRIES-1:0]   alloc_oh;

    // Qualify the command: only codes 0..3 act on the entries.
    always_comb begin
        inv_legal = inv_code_legal(inv_type);
        inv_go    = inv_valid && inv_legal;
    end

    // One slot per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        ctx_tlb_entry #(
            .CTX_W (CTX_W),
            .VPN_W (VPN_W),
            .PPN_W (PPN_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cur_ctx    (cur_ctx),
            .lk_vpn     (lk_vpn),
            .fill_vpn   (fill_vpn),
            .fill_ppn   (fill_ppn),
            .fill_glb   (fill_global),
            .wr_en      (wr_en[g]),
            .inv_go     (inv_go),
            .inv_kind   (inv_type),
            .inv_ctx    (inv_ctx),
            .inv_vpn    (inv_vpn),
            .lk_match   (lk_match[g]),
            .fill_match (fill_match[g]),
            .ppn_o      (ppn_arr[g])
        );
    end

    // Lowest matching slot supplies the lookup result.
    ctx_tlb_pick #(.N(ENTRIES)) u_lk_pick (
        .req   (lk_match),
        .grant (lk_grant),
        .idx   (lk_idx),
        .any   (lk_any)
    );

    // Lowest matching slot is overwritten by a fill of the same page.
    ctx_tlb_pick #(.N(ENTRIES)) u_fill_pick (
        .req   (fill_match),
        .grant (fill_grant),
        .idx   (fill_idx),
        .any   (fill_any)
    );

    // Round-robin pointer for fills that match nothing.
    ctx_tlb_rr #(.N(ENTRIES)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .alloc (alloc),
        .ptr   (rr_ptr)
    );

    // Choose the slot a fill writes: in place on a match, else the pointer.
    always_comb begin
        alloc    = fill_valid && !fill_any;
        alloc_oh = '0;
        alloc_oh[rr_ptr] = 1'b1;
        wr_en    = '0;
        if (fill_valid) begin
            wr_en = fill_any ? fill_grant : alloc_oh;
        end
    end

    // Select the physical page of the winning lookup slot.
    always_comb begin
        ppn_sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            ppn_sel = ppn_sel | (ppn_arr[i] & {PPN_W{lk_grant[i]}});
        end
    end

    // Register lookup result and the illegal-command flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit  <= 1'b0;
            lk_ppn  <= '0;
            inv_err <= 1'b0;
        end else begin
            lk_hit  <= lk_valid && lk_any;
            lk_ppn  <= (lk_valid && lk_any) ? ppn_sel : '0;
            inv_err <= inv_valid && !inv_legal;
        end
    end

    // R12: an illegal code raises the flag in the next cycle.
    p_err_raise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_type > 3'd3) |=> inv_err);

    // R12: the flag stays low after any cycle without an illegal code.
    p_err_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_valid && inv_type > 3'd3) |=> !inv_err);

    // R2: without a lookup request there is no hit in the next cycle.
    p_idle_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!lk_hit && lk_ppn == '0));

    // R10: a fill writes exactly one slot.
    p_fill_one_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> $onehot(wr_en));

    // R11: a fill that matches a slot does not move the pointer.
    p_inplace_no_alloc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_any) |=> $stable(rr_ptr));

endmodule

// File: tb/ctx_tlb_tb.sv
`timescale 1ns/1ps
module ctx_tlb_tb;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] cur_ctx = '0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_global = 1'b0;
    logic        inv_valid = 1'b0;
    logic [2:0]  inv_type = '0;
    logic [11:0] inv_ctx = '0;
    logic [19:0] inv_vpn = '0;
    logic        inv_err;

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit        m_v   [N];
    bit        m_g   [N];
    bit [11:0] m_ctx [N];
    bit [19:0] m_vpn [N];
    bit [19:0] m_ppn [N];
    int        m_rr = 0;

    always #4 clk = ~clk;  // 125 MHz

    ctx_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .cur_ctx(cur_ctx),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_global(fill_global), .inv_valid(inv_valid), .inv_type(inv_type),
        .inv_ctx(inv_ctx), .inv_vpn(inv_vpn), .inv_err(inv_err)
    );

    function automatic bit kills(int i, bit iv, bit [2:0] it, bit [11:0] ic, bit [19:0] ia);
        if (!iv || !m_v[i]) return 1'b0;
        case (it)
            3'd0: return !m_g[i] && m_ctx[i] == ic && m_vpn[i] == ia;
            3'd1: return !m_g[i] && m_ctx[i] == ic;
            3'd2: return 1'b1;
            3'd3: return !m_g[i];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, model, then check a period later.
    task automatic step(string tag, bit lv, bit [19:0] lva, bit fv, bit [19:0] fva,
                        bit [19:0] fpa, bit fg, bit iv, bit [2:0] it,
                        bit [11:0] ic, bit [19:0] ia);
        bit pv [N];
        bit e_hit = 0;
        bit [19:0] e_ppn = '0;
        bit e_err;
        int tgt = -1;
        lk_valid = lv; lk_vpn = lva; fill_valid = fv; fill_vpn = fva;
        fill_ppn = fpa; fill_global = fg; inv_valid = iv; inv_type = it;
        inv_ctx = ic; inv_vpn = ia;
        for (int i = 0; i < N; i++) pv[i] = m_v[i] && !kills(i, iv, it, ic, ia);
        for (int i = N - 1; i >= 0; i--) begin
            if (lv && pv[i] && m_vpn[i] == lva && (m_g[i] || m_ctx[i] == cur_ctx)) begin
                e_hit = 1; e_ppn = m_ppn[i];
            end
            if (fv && pv[i] && m_vpn[i] == fva && (m_g[i] || m_ctx[i] == cur_ctx)) tgt = i;
        end
        e_err = iv && it > 3'd3;
        for (int i = 0; i < N; i++) m_v[i] = pv[i];
        if (fv) begin
            if (tgt < 0) begin
                tgt = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_v[tgt] = 1; m_g[tgt] = fg; m_ctx[tgt] = cur_ctx;
            m_vpn[tgt] = fva; m_ppn[tgt] = fpa;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "lk_hit", 32'(lk_hit), 32'(e_hit));
        if (lv) check(tag, "lk_ppn", 32'(lk_ppn), 32'(e_ppn));
        check(tag, "inv_err", 32'(inv_err), 32'(e_err));
        lk_valid = 0; fill_valid = 0; inv_valid = 0;
    endtask

    task automatic look(string tag, bit [19:0] a);
        step(tag, 1, a, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(string tag, bit [19:0] a, bit [19:0] p, bit g);
        step(tag, 0, 0, 1, a, p, g, 0, 0, 0, 0);
    endtask

    task automatic inval(string tag, bit [2:0] t, bit [11:0] c, bit [19:0] a);
        step(tag, 0, 0, 0, 0, 0, 0, 1, t, c, a);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20141121));
        for (int i = 0; i < N; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "lk_hit after reset", 32'(lk_hit), 32'd0);
        check("R1", "inv_err after reset", 32'(inv_err), 32'd0);
        look("R1", 20'h00100);
        look("R1", 20'h00000);

        // R2 / R4: context tagging and residency across switches
        cur_ctx = 12'd5;
        fill("R2", 20'h00100, 20'h0AAAA, 0);
        look("R2", 20'h00100);
        cur_ctx = 12'd6;
        look("R2", 20'h00100);
        cur_ctx = 12'd5;
        look("R4", 20'h00100);

        // R3: global entry hits under any context
        fill("R3", 20'h00200, 20'h0BBBB, 1);
        cur_ctx = 12'd9;
        look("R3", 20'h00200);
        cur_ctx = 12'hFFF;
        look("R3", 20'h00200);

        // R5 / R9: page invalidation with a lookup in the same cycle
        cur_ctx = 12'd5;
        step("R9", 1, 20'h00100, 0, 0, 0, 0, 1, 3'd0, 12'd5, 20'h00100);
        step("R5", 1, 20'h00200, 0, 0, 0, 0, 1, 3'd0, 12'd5, 20'h00200);
        look("R5", 20'h00200);

        // R9: same-cycle fill is written after the flush, lookup is pre-fill
        step("R9", 1, 20'h00110, 1, 20'h00110, 20'h01234, 0, 1, 3'd3, 12'd0, 20'h0);
        look("R9", 20'h00110);

        // R6: context flush
        cur_ctx = 12'd7;
        fill("R6", 20'h00300, 20'h03007, 0);
        cur_ctx = 12'd5;
        fill("R6", 20'h00300, 20'h03005, 0);
        inval("R6", 3'd1, 12'd7, 20'h0);
        look("R6", 20'h00300);
        cur_ctx = 12'd7;
        look("R6", 20'h00300);

        // R8 / R7: flush all but globals, then everything
        cur_ctx = 12'd5;
        inval("R8", 3'd3, 12'd0, 20'h0);
        look("R8", 20'h00300);
        look("R8", 20'h00200);
        inval("R7", 3'd2, 12'd0, 20'h0);
        look("R7", 20'h00200);

        // R12: illegal codes change nothing and pulse the flag
        fill("R12", 20'h00400, 20'h04444, 0);
        inval("R12", 3'd5, 12'd5, 20'h00400);
        look("R12", 20'h00400);
        inval("R12", 3'd7, 12'd5, 20'h00400);
        inval("R12", 3'd4, 12'd5, 20'h00400);
        look("R12", 20'h00400);

        // R10: overwrite in place
        fill("R10", 20'h00400, 20'h05555, 0);
        look("R10", 20'h00400);

        // R11: fill the whole array, then allocate one more
        inval("R11", 3'd2, 12'd0, 20'h0);
        for (int i = 0; i < N; i++) fill("R11", 20'h00500 + 20'(i), 20'h10000 + 20'(i), 0);
        for (int i = 0; i < N; i++) look("R11", 20'h00500 + 20'(i));
        fill("R11", 20'h00600, 20'h06666, 0);
        for (int i = 0; i < N; i++) look("R11", 20'h00500 + 20'(i));
        look("R11", 20'h00600);

        // Random traffic against the model (R2 general behaviour)
        for (int n = 0; n < 3000; n++) begin
            bit [2:0] t;
            bit [11:0] ctxs [4];
            ctxs[0] = 12'd1; ctxs[1] = 12'd2; ctxs[2] = 12'd3; ctxs[3] = 12'hFFF;
            if ($urandom % 8 == 0) cur_ctx = ctxs[$urandom % 4];
            t = 3'($urandom % 8);
            if (t == 3'd2 && ($urandom % 4) != 0) t = 3'd0;
            step("R2", ($urandom % 10) < 7, 20'($urandom % 24),
                 ($urandom % 10) < 3, 20'($urandom % 24), 20'($urandom),
                 ($urandom % 5) == 0, ($urandom % 10) == 0, t,
                 ctxs[$urandom % 4], 20'($urandom % 24));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule